// File: doc/BRIEF.md
# Indexed Block Configuration Register Slave

This block is a two-wire serial slave that opens a small bank of 8-bit configuration registers to a bus host. Every write carries a starting index and a byte count, followed by that many data bytes, which land in consecutive registers. A read first sets the index with a short write, then uses a repeated start and the read address. The slave answers with a count byte taken from the count register, then streams registers from the index upward until the host declines a byte.

Both bus lines are sampled in a faster system clock domain. Each line passes through a synchronizer and a stability filter before start, stop and clock edges are detected. The slave pulls the data line low through an open-drain enable. The register contents leave the block on a flat output vector for the rest of the device.

Register contents are fixed by the design. One register holds a read-only identity byte: the revision code in the high nibble and 0001 in the low nibble. One register holds the read count in its low six bits. Indices past the last implemented register read as zero and discard writes.

Top module: `cfgbus_slave`

## Requirements
- R1: After reset, register 4 is 0xFF, register 7 is 0x11, register 10 is 0x03, register 12 is 0x0D, and every other register is 0x00. The data line is released.
- R2: The 8-bit addresses 0xD2 (write) and 0xD3 (read) are acknowledged. Any other address gets no acknowledge. The data line stays released until the next start or stop, and no register changes.
- R3: A write of start, 0xD2, index N, count X and X data bytes stores them in registers N to N+X-1. Each byte is acknowledged, and the new value shows on the register output before the stop.
- R4: A data byte sent after the X counted bytes is not acknowledged and changes no register.
- R5: A read of start, 0xD2, index N, repeated start and 0xD3 returns a count byte first, then registers N, N+1 and so on, for as long as the host acknowledges. All bytes are sent MSB first.
- R6: After the host answers a byte with a not-acknowledge, the slave drives nothing until the next start. A further byte clocked by the host reads as 0xFF.
- R7: Register 7 is read-only. Writes to it are acknowledged but leave it at 0x11.
- R8: Register 12 keeps only bits 5:0, and bits 7:6 read as 0. The count byte sent on a read is the value of those bits, capped at 32 (0x20).
- R9: At an index of 13 or more, written bytes are acknowledged and discarded, and read bytes are 0x00.
- R10: A stop at any point returns the slave to idle with the data line released. A start or repeated start at any point begins a new address phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the bus clock |
| rstN | input | 1 | Asynchronous active-low reset |
| scl | input | 1 | Bus clock line as seen at the pin |
| sda | input | 1 | Bus data line as seen at the pin |
| sdaDriveLow | output | 1 | When 1, the pad pulls the data line low |
| cfgRegs | output | 104 | Register bank, register i in bits 8i+7:8i |

## Verification
A bus line change reaches the filtered copy about five system cycles later. The control logic reacts on the next edge, so the data line the slave drives moves about seven cycles after the host's clock edge. A register takes its new value one cycle after the byte-ending clock fall. The bench holds each quarter of a bus bit for 16 system cycles. It changes data only in the middle of the clock-low phase and samples the data line in the middle of the clock-high phase, so every slave response has settled with margin. Register outputs are compared only after the stop condition, many cycles after the last strobe. Read bytes go to a scoreboard and are compared in the order they were expected.

// File: rtl/cfgbus_pkg.sv
package cfgbus_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_RXACK,
    ST_TX,
    ST_TXACK,
    ST_WAIT
  } busState_t;

  typedef enum logic [1:0] {
    K_ADDR,
    K_INDEX,
    K_COUNT,
    K_DATA
  } rxKind_t;

  typedef struct packed {
    logic       wrEn;
    logic [7:0] idx;
    logic [7:0] data;
  } regStrobe_t;

endpackage

// File: rtl/cfgbus_filt.sv
module cfgbus_filt #(
  parameter int SYNC_STAGES   = 2,
  parameter int STABLE_CYCLES = 3
) (
  input  logic clk,
  input  logic rstN,
  input  logic lineIn,
  output logic lineOut
);
  localparam int CW = $clog2(STABLE_CYCLES + 1);

  logic [SYNC_STAGES-1:0] syncQ;
  logic [CW-1:0]          stableCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ     <= '1;
      stableCnt <= '0;
      lineOut   <= 1'b1;
    end else begin
      syncQ <= {syncQ[SYNC_STAGES-2:0], lineIn};
      if (syncQ[SYNC_STAGES-1] == lineOut) begin
        stableCnt <= '0;
      end else if (stableCnt == CW'(STABLE_CYCLES - 1)) begin
        lineOut   <= syncQ[SYNC_STAGES-1];
        stableCnt <= '0;
      end else begin
        stableCnt <= stableCnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/cfgbus_ctrl.sv
module cfgbus_ctrl
  import cfgbus_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h69
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclF,
  input  logic       sdaF,
  input  logic [7:0] rdData,
  input  logic [7:0] countByte,
  output regStrobe_t strobe,
  output logic [7:0] rdIdx,
  output logic       sdaLow,
  output busState_t  state
);
  logic       sclQ, sdaQ;
  logic       sclRise, sclFall, startDet, stopDet;
  rxKind_t    kind;
  logic [7:0] shReg, txSh, ptr, left;
  logic [3:0] bitCnt;
  logic       readDir, hostAck;

  assign sclRise  = sclF & ~sclQ;
  assign sclFall  = ~sclF & sclQ;
  assign startDet = sclF & sclQ & sdaQ & ~sdaF;
  assign stopDet  = sclF & sclQ & ~sdaQ & sdaF;
  assign rdIdx    = ptr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclQ    <= 1'b1;
      sdaQ    <= 1'b1;
      state   <= ST_IDLE;
      kind    <= K_ADDR;
      shReg   <= '0;
      txSh    <= '0;
      ptr     <= '0;
      left    <= '0;
      bitCnt  <= '0;
      readDir <= 1'b0;
      hostAck <= 1'b0;
      sdaLow  <= 1'b0;
      strobe  <= '0;
    end else begin
      sclQ        <= sclF;
      sdaQ        <= sdaF;
      strobe.wrEn <= 1'b0;
      if (stopDet) begin
        state  <= ST_IDLE;
        sdaLow <= 1'b0;
      end else if (startDet) begin
        state  <= ST_RX;
        kind   <= K_ADDR;
        bitCnt <= '0;
        sdaLow <= 1'b0;
      end else begin
        case (state)
          ST_RX: begin
            if (sclRise && bitCnt != 4'd8) begin
              shReg  <= {shReg[6:0], sdaF};
              bitCnt <= bitCnt + 1'b1;
            end else if (sclFall && bitCnt == 4'd8) begin
              case (kind)
                K_ADDR: begin
                  if (shReg[7:1] == DEV_ADDR) begin
                    readDir <= shReg[0];
                    kind    <= K_INDEX;
                    sdaLow  <= 1'b1;
                    state   <= ST_RXACK;
                  end else begin
                    state <= ST_WAIT;
                  end
                end
                K_INDEX: begin
                  ptr    <= shReg;
                  kind   <= K_COUNT;
                  sdaLow <= 1'b1;
                  state  <= ST_RXACK;
                end
                K_COUNT: begin
                  left   <= shReg;
                  kind   <= K_DATA;
                  sdaLow <= 1'b1;
                  state  <= ST_RXACK;
                end
                default: begin
                  if (left != 8'd0) begin
                    strobe.wrEn <= 1'b1;
                    strobe.idx  <= ptr;
                    strobe.data <= shReg;
                    ptr         <= ptr + 1'b1;
                    left        <= left - 1'b1;
                    sdaLow      <= 1'b1;
                    state       <= ST_RXACK;
                  end else begin
                    state <= ST_WAIT;
                  end
                end
              endcase
            end
          end
          ST_RXACK: begin
            if (sclFall) begin
              if (readDir) begin
                sdaLow <= ~countByte[7];
                txSh   <= {countByte[6:0], 1'b0};
                bitCnt <= 4'd1;
                state  <= ST_TX;
              end else begin
                sdaLow <= 1'b0;
                bitCnt <= '0;
                state  <= ST_RX;
              end
            end
          end
          ST_TX: begin
            if (sclFall) begin
              if (bitCnt == 4'd8) begin
                sdaLow <= 1'b0;
                state  <= ST_TXACK;
              end else begin
                sdaLow <= ~txSh[7];
                txSh   <= {txSh[6:0], 1'b0};
                bitCnt <= bitCnt + 1'b1;
              end
            end
          end
          ST_TXACK: begin
            if (sclRise) begin
              hostAck <= ~sdaF;
            end else if (sclFall) begin
              if (hostAck) begin
                sdaLow <= ~rdData[7];
                txSh   <= {rdData[6:0], 1'b0};
                ptr    <= ptr + 1'b1;
                bitCnt <= 4'd1;
                state  <= ST_TX;
              end else begin
                state <= ST_WAIT;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/cfgbus_regs.sv
module cfgbus_regs
  import cfgbus_pkg::*;
#(
  parameter int         NUM_REGS   = 13,
  parameter int         ENABLE_IDX = 4,
  parameter int         ID_IDX     = 7,
  parameter int         STOPEN_IDX = 10,
  parameter int         COUNT_IDX  = 12,
  parameter int         COUNT_MAX  = 32,
  parameter logic [3:0] REV_CODE   = 4'h1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  regStrobe_t            strobe,
  input  logic [7:0]            rdIdx,
  output logic [7:0]            rdData,
  output logic [7:0]            countByte,
  output logic [NUM_REGS*8-1:0] cfgRegs
);
  localparam logic [7:0] ID_VALUE = {REV_CODE, 4'b0001};

  logic [7:0] regArr [NUM_REGS];

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    localparam logic [7:0] RST_VAL =
      (i == ENABLE_IDX) ? 8'hFF :
      (i == ID_IDX)     ? ID_VALUE :
      (i == STOPEN_IDX) ? 8'h03 :
      (i == COUNT_IDX)  ? 8'h0D : 8'h00;
    localparam logic [7:0] WR_MASK =
      (i == ID_IDX) ? 8'h00 : (i == COUNT_IDX) ? 8'h3F : 8'hFF;

    if (WR_MASK == 8'h00) begin : g_ro
      assign regArr[i] = RST_VAL;
    end else begin : g_rw
      logic [7:0] q;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          q <= RST_VAL;
        end else if (strobe.wrEn && strobe.idx == 8'(i)) begin
          q <= (q & ~WR_MASK) | (strobe.data & WR_MASK);
        end
      end
      assign regArr[i] = q;
    end
    assign cfgRegs[i*8 +: 8] = regArr[i];
  end

  always_comb begin
    rdData = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (rdIdx == 8'(i)) rdData = regArr[i];
    end
  end

  logic [7:0] rawCount;
  assign rawCount  = {2'b00, regArr[COUNT_IDX][5:0]};
  assign countByte = (rawCount > 8'(COUNT_MAX)) ? 8'(COUNT_MAX) : rawCount;
endmodule

// File: rtl/cfgbus_slave.sv
module cfgbus_slave
  import cfgbus_pkg::*;
#(
  parameter int         NUM_REGS      = 13,
  parameter logic [6:0] DEV_ADDR      = 7'h69,
  parameter logic [3:0] REV_CODE      = 4'h1,
  parameter int         SYNC_STAGES   = 2,
  parameter int         STABLE_CYCLES = 3
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  scl,
  input  logic                  sda,
  output logic                  sdaDriveLow,
  output logic [NUM_REGS*8-1:0] cfgRegs
);
  logic [1:0] rawLines, cleanLines;
  regStrobe_t strobe;
  busState_t  busSt;
  logic [7:0] rdIdx, rdData, countByte;

  assign rawLines = {scl, sda};

  for (genvar g = 0; g < 2; g++) begin : g_filt
    cfgbus_filt #(
      .SYNC_STAGES  (SYNC_STAGES),
      .STABLE_CYCLES(STABLE_CYCLES)
    ) u_filt (
      .clk    (clk),
      .rstN   (rstN),
      .lineIn (rawLines[g]),
      .lineOut(cleanLines[g])
    );
  end

  cfgbus_ctrl #(.DEV_ADDR(DEV_ADDR)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .sclF     (cleanLines[1]),
    .sdaF     (cleanLines[0]),
    .rdData   (rdData),
    .countByte(countByte),
    .strobe   (strobe),
    .rdIdx    (rdIdx),
    .sdaLow   (sdaDriveLow),
    .state    (busSt)
  );

  cfgbus_regs #(
    .NUM_REGS(NUM_REGS),
    .REV_CODE(REV_CODE)
  ) u_regs (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .rdIdx    (rdIdx),
    .rdData   (rdData),
    .countByte(countByte),
    .cfgRegs  (cfgRegs)
  );
endmodule

// File: rtl/cfgbus_checker.sv
module cfgbus_checker
  import cfgbus_pkg::*;
#(
  parameter int NUM_REGS  = 13,
  parameter int ID_IDX    = 7,
  parameter int COUNT_IDX = 12
) (
  input logic                  clk,
  input logic                  rstN,
  input regStrobe_t            strobe,
  input busState_t             state,
  input logic                  sdaDriveLow,
  input logic [NUM_REGS*8-1:0] cfgRegs
);
  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrEn && int'(strobe.idx) < NUM_REGS && int'(strobe.idx) != ID_IDX
     && int'(strobe.idx) != COUNT_IDX)
    |=> cfgRegs[int'($past(strobe.idx))*8 +: 8] == $past(strobe.data)); // R3

  AST_ID_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrEn && int'(strobe.idx) == ID_IDX)
    |=> $stable(cfgRegs[ID_IDX*8 +: 8])); // R7

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrEn && int'(strobe.idx) == COUNT_IDX)
    |=> cfgRegs[COUNT_IDX*8+6 +: 2] == 2'b00); // R8

  AST_OOR_NOWRITE: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrEn && int'(strobe.idx) >= NUM_REGS)
    |=> $stable(cfgRegs)); // R9

  AST_IDLE_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE) |-> !sdaDriveLow); // R10

  AST_FOREIGN_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAIT) |-> !sdaDriveLow); // R2
endmodule

bind cfgbus_slave cfgbus_checker #(
  .NUM_REGS(NUM_REGS)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .strobe     (strobe),
  .state      (busSt),
  .sdaDriveLow(sdaDriveLow),
  .cfgRegs    (cfgRegs)
);

// File: tb/tb_cfgbus_slave.sv
module tb_cfgbus_slave;
  localparam int Q        = 16;
  localparam int NUM_REGS = 13;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1;
  logic sdaM = 1'b1;
  logic sdaDriveLow;
  logic sdaBus;
  logic [NUM_REGS*8-1:0] cfgRegs;

  assign sdaBus = sdaM & ~sdaDriveLow;

  always #5 clk = ~clk;

  cfgbus_slave dut (
    .clk        (clk),
    .rstN       (rstN),
    .scl        (sclM),
    .sda        (sdaBus),
    .sdaDriveLow(sdaDriveLow),
    .cfgRegs    (cfgRegs)
  );

  int nRun = 0;
  int nFail = 0;

  logic [7:0] expVal[$];
  string      expTag[$];
  logic [7:0] obsVal[$];
  event       obsEv;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] regAt(input int i);
    return cfgRegs[i*8 +: 8];
  endfunction

  // scoreboard monitor: compares each observed read byte against the oldest expectation
  initial begin
    forever begin
      @(obsEv);
      while (obsVal.size() > 0) begin
        logic [7:0] got;
        got = obsVal.pop_front();
        if (expVal.size() == 0) begin
          check("unexpected byte", {24'd0, got}, 32'h100);
        end else begin
          string t;
          logic [7:0] e;
          e = expVal.pop_front();
          t = expTag.pop_front();
          check(t, {24'd0, got}, {24'd0, e});
        end
      end
    end
  end

  task automatic expectByte(input logic [7:0] v, input string tag);
    expVal.push_back(v);
    expTag.push_back(tag);
  endtask

  task automatic waitQ();
    repeat (Q) @(negedge clk);
  endtask

  task automatic xferBit(input logic b, output logic r);
    waitQ();
    sdaM = b;
    waitQ();
    sclM = 1'b1;
    waitQ();
    r = sdaBus;
    waitQ();
    sclM = 1'b0;
  endtask

  task automatic startCond();
    waitQ();
    sdaM = 1'b1;
    waitQ();
    sclM = 1'b1;
    waitQ();
    sdaM = 1'b0;
    waitQ();
    sclM = 1'b0;
  endtask

  task automatic stopCond();
    waitQ();
    sdaM = 1'b0;
    waitQ();
    sclM = 1'b1;
    waitQ();
    sdaM = 1'b1;
    waitQ();
    waitQ();
  endtask

  task automatic writeByte(input logic [7:0] b, output logic acked);
    logic r;
    for (int i = 7; i >= 0; i--) xferBit(b[i], r);
    xferBit(1'b1, r);
    acked = ~r;
  endtask

  task automatic readByte(input logic hostAck);
    logic [7:0] b;
    logic r;
    for (int i = 7; i >= 0; i--) begin
      xferBit(1'b1, r);
      b[i] = r;
    end
    xferBit(~hostAck, r);
    obsVal.push_back(b);
    ->obsEv;
  endtask

  task automatic sendChecked(input logic [7:0] b, input logic expAck, input string tag);
    logic a;
    writeByte(b, a);
    check(tag, {31'd0, a}, {31'd0, expAck});
  endtask

  // block write with count equal to the number of data bytes
  task automatic blockWrite(input logic [7:0] idx, input logic [7:0] d[], input string tag);
    startCond();
    sendChecked(8'hD2, 1'b1, tag);
    sendChecked(idx, 1'b1, tag);
    sendChecked(8'(d.size()), 1'b1, tag);
    foreach (d[i]) sendChecked(d[i], 1'b1, tag);
    stopCond();
  endtask

  // block read: count byte then n data bytes, last one not acknowledged
  task automatic blockRead(input logic [7:0] idx, input int n, input bit doStop, input string tag);
    startCond();
    sendChecked(8'hD2, 1'b1, tag);
    sendChecked(idx, 1'b1, tag);
    startCond();
    sendChecked(8'hD3, 1'b1, tag);
    readByte(n > 0);
    for (int i = 0; i < n; i++) readByte(i < n - 1);
    if (doStop) stopCond();
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    logic [NUM_REGS*8-1:0] snap;
    logic a;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset values
    check("R1 reg0", {24'd0, regAt(0)}, 32'h00);
    check("R1 reg4", {24'd0, regAt(4)}, 32'hFF);
    check("R1 reg7", {24'd0, regAt(7)}, 32'h11);
    check("R1 reg10", {24'd0, regAt(10)}, 32'h03);
    check("R1 reg12", {24'd0, regAt(12)}, 32'h0D);
    check("R1 sda released", {31'd0, sdaDriveLow}, 32'd0);

    // R5 full read of defaults, count first
    expectByte(8'h0D, "R5 count");
    for (int i = 0; i < NUM_REGS; i++) begin
      expectByte(i == 4 ? 8'hFF : i == 7 ? 8'h11 : i == 10 ? 8'h03 : i == 12 ? 8'h0D : 8'h00,
                 "R5 data");
    end
    blockRead(8'd0, NUM_REGS, 1'b1, "R5 acks");

    // R3 block write and readback
    blockWrite(8'd2, '{8'hA5, 8'h5A, 8'h3C}, "R3 acks");
    check("R3 reg2", {24'd0, regAt(2)}, 32'hA5);
    check("R3 reg3", {24'd0, regAt(3)}, 32'h5A);
    check("R3 reg4", {24'd0, regAt(4)}, 32'h3C);
    expectByte(8'h0D, "R3 count");
    expectByte(8'hA5, "R3 rd2");
    expectByte(8'h5A, "R3 rd3");
    expectByte(8'h3C, "R3 rd4");
    blockRead(8'd2, 3, 1'b1, "R3 read acks");

    // R4 byte beyond count
    startCond();
    sendChecked(8'hD2, 1'b1, "R4 addr");
    sendChecked(8'd0, 1'b1, "R4 idx");
    sendChecked(8'd1, 1'b1, "R4 cnt");
    sendChecked(8'h11, 1'b1, "R4 first");
    sendChecked(8'h22, 1'b0, "R4 extra nack");
    stopCond();
    check("R4 reg0", {24'd0, regAt(0)}, 32'h11);
    check("R4 reg1 untouched", {24'd0, regAt(1)}, 32'h00);

    // R2 foreign address
    snap = cfgRegs;
    startCond();
    sendChecked(8'hA0, 1'b0, "R2 foreign nack");
    sendChecked(8'h00, 1'b0, "R2 stays released");
    stopCond();
    check("R2 regs unchanged", {31'd0, cfgRegs == snap}, 32'd1);

    // R7 read-only identity
    blockWrite(8'd6, '{8'h77, 8'h00}, "R7 acks");
    check("R7 reg6", {24'd0, regAt(6)}, 32'h77);
    check("R7 reg7 kept", {24'd0, regAt(7)}, 32'h11);

    // R8 count register masking and cap, R9 read past end
    blockWrite(8'd12, '{8'hFF}, "R8 acks");
    check("R8 reg12 masked", {24'd0, regAt(12)}, 32'h3F);
    expectByte(8'h20, "R8 count capped");
    expectByte(8'h3F, "R8 rd12");
    expectByte(8'h00, "R9 rd13");
    blockRead(8'd12, 2, 1'b1, "R8 read acks");
    blockWrite(8'd12, '{8'h1F}, "R8 acks2");
    expectByte(8'h1F, "R8 count below cap");
    expectByte(8'h00, "R8 rd11");
    blockRead(8'd11, 1, 1'b1, "R8 read acks2");

    // R9 writes past the end
    snap = cfgRegs;
    blockWrite(8'd13, '{8'hAB, 8'hCD}, "R9 acks");
    check("R9 regs unchanged", {31'd0, cfgRegs == snap}, 32'd1);
    blockWrite(8'd12, '{8'h05, 8'hEE}, "R9 acks straddle");
    check("R9 reg12", {24'd0, regAt(12)}, 32'h05);

    // R6 host NACK ends the stream
    expectByte(8'h05, "R6 count");
    expectByte(8'h11, "R6 rd0");
    expectByte(8'hFF, "R6 released after nack");
    blockRead(8'd0, 1, 1'b0, "R6 acks");
    readByte(1'b0);
    stopCond();

    // R10 abort with stop, then repeated start mid-write
    startCond();
    sendChecked(8'hD2, 1'b1, "R10 addr");
    sendChecked(8'd3, 1'b1, "R10 idx");
    stopCond();
    check("R10 idle released", {31'd0, sdaDriveLow}, 32'd0);
    blockWrite(8'd5, '{8'h99}, "R10 after stop");
    check("R10 reg5", {24'd0, regAt(5)}, 32'h99);
    startCond();
    sendChecked(8'hD2, 1'b1, "R10 a");
    sendChecked(8'd8, 1'b1, "R10 b");
    sendChecked(8'd2, 1'b1, "R10 c");
    sendChecked(8'h44, 1'b1, "R10 d");
    startCond();
    sendChecked(8'hD2, 1'b1, "R10 e");
    sendChecked(8'd9, 1'b1, "R10 f");
    sendChecked(8'd1, 1'b1, "R10 g");
    sendChecked(8'h55, 1'b1, "R10 h");
    stopCond();
    check("R10 reg8", {24'd0, regAt(8)}, 32'h44);
    check("R10 reg9", {24'd0, regAt(9)}, 32'h55);

    repeat (10) @(negedge clk);
    if (expVal.size() != 0) begin
      check("missing read bytes", expVal.size(), 32'd0);
    end
    a = 1'b0;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule